// File: doc/BRIEF.md
# Mixed-Access Register Bank

This block is a small memory-mapped register bank behind a plain read/write bus. Each location's access behaviour is fixed at elaboration by one packed parameter table. A location can be empty, read-only, write-only, read/write, write-1-to-clear, or paired. A paired location returns a hardware-driven value on a read and loads a separate stored register on a write. Two wide vectors connect the bank to the surrounding hardware. One supplies the values that read-only and paired locations return. The other carries per-bit set events for the write-1-to-clear locations.

The bus has no back-pressure. A write is taken on any clock edge where `bus_wr` is high. A read is taken on any edge where `bus_rd` is high, and its data appears on `bus_rdata` during the following cycle. When no read was taken on the previous edge, `bus_rdata` is zero. Every stored register is visible at all times on `reg_q`, so the logic around the bank uses the written values directly.

Top module: `regbank_mixed`

## Requirements
- R1: After reset, every writable location (read/write, write-only, write-1-to-clear, paired) holds its entry from the reset-value parameter. `bus_rdata` is zero, and `reg_q` slices of read-only and empty locations are zero.
- R2: A read of a read/write location returns the most recent value written to it.
- R3: A read of a read-only location returns that location's `hw_value` slice. A write to it changes nothing: its `reg_q` slice stays zero and later reads still follow `hw_value`.
- R4: A write to a write-only location loads its `reg_q` slice. A read of it returns zero and leaves the slice unchanged.
- R5: A read of a paired location returns its `hw_value` slice. A write to it loads its `reg_q` slice instead.
- R6: On a write-1-to-clear location, each written 1 clears the matching stored bit, and each written 0 leaves the bit unchanged.
- R7: A high `hw_set` bit sets the matching write-1-to-clear bit on the next edge. When a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: An address beyond the table or marked empty reads as zero. Writing it changes no register.
- R9: Read data appears in the cycle after `bus_rd`, and is zero otherwise. A read and a write to the same location on the same edge return the value from before the write.
- Default table (3-bit codes, empty=0, RO=1, WO=2, RW=3, W1C=4, paired=5): location 0 RW, 1 RO, 2 WO, 3 W1C, 4 paired, 5 RW, 6 and 7 empty. Address width is 4, so addresses 8 to 15 are unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Location index for the read or write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DW | Read data, one cycle after the strobe |
| hw_value | input | N_LOC*DW | Per-location value returned by read-only and paired locations |
| hw_set | input | N_LOC*DW | Per-bit set events for write-1-to-clear locations |
| reg_q | output | N_LOC*DW | Stored register contents per location |

## Verification
Several properties are checked on every cycle. Write-loaded registers take the written data. They hold when not written. Write-1-to-clear bits clear under a write and are forced set by an event. Read data is zero after an idle cycle and after an unmapped read. Some behaviours need the bench's scenarios instead. Reads of read-only and paired locations must track `hw_value` while writes go elsewhere. A write-only read must disturb nothing. The set and clear collision must resolve to set. A read colliding with a write must return the old value.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    LOC_EMPTY = 3'd0,
    LOC_RO    = 3'd1,
    LOC_WO    = 3'd2,
    LOC_RW    = 3'd3,
    LOC_W1C   = 3'd4,
    LOC_PAIR  = 3'd5
  } loc_kind_e;

  function automatic bit kind_stores(loc_kind_e k);
    return (k == LOC_RW) || (k == LOC_WO) || (k == LOC_W1C) || (k == LOC_PAIR);
  endfunction
endpackage

// File: rtl/regbank_cell.sv
module regbank_cell
  import regbank_pkg::*;
#(
  parameter loc_kind_e   KIND = LOC_RW,
  parameter int          DW   = 16,
  parameter logic [DW-1:0] RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_val,
  input  logic [DW-1:0] set_ev,
  output logic [DW-1:0] q,
  output logic [DW-1:0] rd_val
);
  localparam bit            STORES = kind_stores(KIND);
  localparam logic [DW-1:0] RST_Q  = STORES ? RST : '0;

  logic [DW-1:0] q_nxt;

  always_comb begin
    q_nxt  = q;
    rd_val = '0;
    case (KIND)
      LOC_RW: begin
        if (wr_hit) q_nxt = wdata;
        rd_val = q;
      end
      LOC_WO: begin
        if (wr_hit) q_nxt = wdata;
      end
      LOC_PAIR: begin
        if (wr_hit) q_nxt = wdata;
        rd_val = hw_val;
      end
      LOC_W1C: begin
        q_nxt  = (q & ~(wr_hit ? wdata : '0)) | set_ev;
        rd_val = q;
      end
      LOC_RO: begin
        q_nxt  = '0;
        rd_val = hw_val;
      end
      default: q_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_Q;
    else        q <= q_nxt;
  end

  generate
    if (KIND == LOC_W1C) begin : g_w1c_chk
      p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ev) |=> ((q & $past(set_ev)) == $past(set_ev)));
      p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !(|set_ev)) |=> (q == ($past(q) & ~$past(wdata))));
    end else if (STORES) begin : g_load_chk
      p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (q == $past(wdata)));
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(q));
    end
  endgenerate
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int N_LOC = 8,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [N_LOC*DW-1:0] vals,
  output logic [DW-1:0]       rdata
);
  logic [DW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_LOC; i++) begin
      if (addr == AW'(i)) sel = vals[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= sel;
    else            rdata <= '0;
  end

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));
  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (int'(addr) >= N_LOC)) |=> (rdata == '0));
endmodule

// File: rtl/regbank_mixed.sv
module regbank_mixed
  import regbank_pkg::*;
#(
  parameter int N_LOC = 8,
  parameter int DW    = 16,
  parameter int AW    = 4,
  parameter logic [N_LOC*KIND_W-1:0] LOC_KIND =
    {3'd0, 3'd0, 3'd3, 3'd5, 3'd4, 3'd2, 3'd1, 3'd3},
  parameter logic [N_LOC*DW-1:0] RST_VAL =
    {16'h0000, 16'h0000, 16'hBEEF, 16'h0042,
     16'h000F, 16'h00A5, 16'h0000, 16'h1234}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic                bus_rd,
  output logic [DW-1:0]       bus_rdata,
  input  logic [N_LOC*DW-1:0] hw_value,
  input  logic [N_LOC*DW-1:0] hw_set,
  output logic [N_LOC*DW-1:0] reg_q
);
  logic [N_LOC*DW-1:0] rd_vals;

  for (genvar i = 0; i < N_LOC; i++) begin : g_loc
    localparam loc_kind_e K = loc_kind_e'(LOC_KIND[i*KIND_W +: KIND_W]);
    logic hit;
    assign hit = bus_wr && (bus_addr == AW'(i));

    regbank_cell #(
      .KIND (K),
      .DW   (DW),
      .RST  (RST_VAL[i*DW +: DW])
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (hit),
      .wdata  (bus_wdata),
      .hw_val (hw_value[i*DW +: DW]),
      .set_ev (hw_set[i*DW +: DW]),
      .q      (reg_q[i*DW +: DW]),
      .rd_val (rd_vals[i*DW +: DW])
    );
  end

  regbank_rdmux #(
    .N_LOC (N_LOC),
    .DW    (DW),
    .AW    (AW)
  ) u_rdmux (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (bus_rd),
    .addr  (bus_addr),
    .vals  (rd_vals),
    .rdata (bus_rdata)
  );
endmodule

// File: tb/regbank_mixed_tb.sv
`timescale 1ns/1ps
module regbank_mixed_tb;
  localparam int N_LOC = 8;
  localparam int DW    = 16;
  localparam int AW    = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [AW-1:0]       bus_addr = '0;
  logic                bus_wr = 1'b0;
  logic [DW-1:0]       bus_wdata = '0;
  logic                bus_rd = 1'b0;
  logic [DW-1:0]       bus_rdata;
  logic [N_LOC*DW-1:0] hw_value = '0;
  logic [N_LOC*DW-1:0] hw_set = '0;
  logic [N_LOC*DW-1:0] reg_q;

  int n_checks = 0;
  int n_fails  = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_seen = 1'b0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  regbank_mixed u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_value(hw_value), .hw_set(hw_set), .reg_q(reg_q)
  );

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] slot(logic [N_LOC*DW-1:0] v, int i);
    return v[i*DW +: DW];
  endfunction

  // monitor: pops one expected item for each read taken on the prior edge
  always @(posedge clk) rd_seen <= bus_rd && rst_n;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R9 unexpected read data", bus_rdata, '0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic cyc(bit rd, bit wr, int a, logic [DW-1:0] wd,
                     logic [DW-1:0] exp, string tag);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = AW'(a); bus_wdata = wd;
    if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; hw_set = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N_LOC*DW-1:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 loc0", slot(reg_q, 0), 16'h1234);
    check("R1 loc1 RO", slot(reg_q, 1), 16'h0000);
    check("R1 loc2 WO", slot(reg_q, 2), 16'h00A5);
    check("R1 loc3 W1C", slot(reg_q, 3), 16'h000F);
    check("R1 loc4 pair", slot(reg_q, 4), 16'h0042);
    check("R1 loc5", slot(reg_q, 5), 16'hBEEF);
    check("R1 rdata", bus_rdata, 16'h0000);

    // R2 read/write
    cyc(1, 0, 0, 0, 16'h1234, "R2 read default");
    cyc(0, 1, 0, 16'hA5A5, 0, "");
    cyc(1, 0, 0, 0, 16'hA5A5, "R2 read back");
    idle();

    // R3 read-only
    hw_value[1*DW +: DW] = 16'h7777;
    cyc(1, 0, 1, 0, 16'h7777, "R3 read hw");
    cyc(0, 1, 1, 16'hFFFF, 0, "");
    cyc(1, 0, 1, 0, 16'h7777, "R3 read after write");
    idle();
    check("R3 reg_q stays zero", slot(reg_q, 1), 16'h0000);
    hw_value[1*DW +: DW] = 16'h1111;
    cyc(1, 0, 1, 0, 16'h1111, "R3 follows hw");
    idle();

    // R4 write-only
    cyc(1, 0, 2, 0, 16'h0000, "R4 read returns zero");
    idle();
    check("R4 read no side effect", slot(reg_q, 2), 16'h00A5);
    cyc(0, 1, 2, 16'h5A5A, 0, "");
    idle();
    check("R4 write loads", slot(reg_q, 2), 16'h5A5A);

    // R5 paired
    hw_value[4*DW +: DW] = 16'hCAFE;
    cyc(1, 0, 4, 0, 16'hCAFE, "R5 read hw side");
    cyc(0, 1, 4, 16'h0101, 0, "");
    cyc(1, 0, 4, 0, 16'hCAFE, "R5 read after write");
    idle();
    check("R5 write side", slot(reg_q, 4), 16'h0101);

    // R6 write-1-to-clear
    cyc(0, 1, 3, 16'h0005, 0, "");
    cyc(1, 0, 3, 0, 16'h000A, "R6 clear ones");
    cyc(0, 1, 3, 16'h0000, 0, "");
    cyc(1, 0, 3, 0, 16'h000A, "R6 zero no effect");
    idle();

    // R7 set events and collision
    @(negedge clk);
    hw_set[3*DW +: DW] = 16'h0010;
    idle();
    check("R7 set bit", slot(reg_q, 3), 16'h001A);
    @(negedge clk);
    hw_set[3*DW +: DW] = 16'h0010;
    bus_wr = 1'b1; bus_addr = AW'(3); bus_wdata = 16'h0012;
    idle();
    check("R7 set wins", slot(reg_q, 3), 16'h0018);
    hw_set[2*DW +: DW] = 16'hFFFF;
    @(negedge clk);
    hw_set = '0;
    check("R7 set ignored off W1C", slot(reg_q, 2), 16'h5A5A);

    // R8 unmapped
    snap = reg_q;
    cyc(0, 1, 6, 16'hFFFF, 0, "");
    cyc(0, 1, 12, 16'hFFFF, 0, "");
    idle();
    check("R8 no reg changed lo", reg_q[63:0], snap[63:0]);
    check("R8 no reg changed hi", reg_q[127:64], snap[127:64]);
    cyc(1, 0, 6, 0, 16'h0000, "R8 read empty loc");
    cyc(1, 0, 13, 0, 16'h0000, "R8 read beyond table");
    idle();

    // R9 timing and read/write collision
    cyc(1, 1, 5, 16'h1111, 16'hBEEF, "R9 old value on collision");
    cyc(1, 0, 5, 0, 16'h1111, "R9 new value after");
    idle();
    @(negedge clk);
    check("R9 idle zero", bus_rdata, 16'h0000);
    idle();
    check("R9 queue drained", 16'(exp_q.size()), 16'd0);
    finish_run();
  end
endmodule